// File: doc/BRIEF.md
# Periodic-Interrupt Real-Time Clock Register Block

This block is the register side of a small real-time clock. Software reaches every register through two ports: a write on the index port picks a register, and strobes on the data port then read or write the register that was picked. Seven binary, 24-hour time and date fields can be read and written freely. The day-of-week field holds a zero-based weekday and reads back as that value plus one.

Four control registers sit above the time fields. They do not hold programmable state. Register A always reports the same timebase and rate setting, plus an update-in-progress flag that inverts after every read of A. Register B always reports the periodic-enable, binary and 24-hour bits. Only a narrow set of writes to A and B is legal. Any other control write, and any write to a slot that has no register, gives a one-cycle error pulse. Bit 6 of a legal write to B starts or stops a periodic interrupt generator. That generator counts pulses of a prescaled tick input and fires one interrupt pulse every `TICKS_PER_IRQ` ticks, then rearms.

Top module: `rtc_periodic_regs`

## Requirements
- R1: After reset the selected index is 0x00 and every time field holds 0x00. A pulse on `idx_wr` loads `wdata` as the new index. Data-port accesses always use the index held at that moment.
- R2: The time fields at indices 0x00 (seconds), 0x02 (minutes), 0x04 (hours), 0x07 (day of month), 0x08 (month) and 0x09 (year) are 8-bit registers. Each one reads back exactly the last value written to it, and writing one field leaves the others unchanged.
- R3: The day-of-week field at index 0x06 stores the written value and reads as (stored + 1) modulo 256.
- R4: A read of index 0x0A returns {flag, 7'h26}. The update flag is 0 after reset and inverts on the clock edge of every data read of 0x0A. Nothing else changes the flag.
- R5: A read of index 0x0B always returns 0x46, whatever has been written to it.
- R6: Reads of 0x0C, 0x0D, the unused slots 0x01, 0x03 and 0x05, and every index above 0x0D return 0x00.
- R7: `bad_wr` is high for exactly the one cycle after a data write in these cases: a write to 0x0A with a value other than 0x26; a write to 0x0B whose value ANDed with 0xB7 is not 0x06; any write to 0x0C or 0x0D; a write to 0x01, 0x03 or 0x05; a write above 0x0D. Legal writes do not raise `bad_wr`, and writes to 0x0A never change what 0x0A reads.
- R8: A legal write to 0x0B with bit 6 set starts the timer if it is idle, with its tick count cleared. If the timer is already running, the count phase is kept. A legal write to 0x0B with bit 6 clear stops the timer. An illegal write to 0x0B leaves the timer as it was.
- R9: The timer is running after reset. While it runs, `irq` is high for one cycle, in the cycle after every `TICKS_PER_IRQ`-th tick pulse counted since the timer started.
- R10: While the timer is stopped, tick pulses produce no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Loads `wdata` into the index register |
| dat_wr | input | 1 | Writes `wdata` to the selected register |
| dat_rd | input | 1 | Marks a data read of the selected register (side effects only) |
| wdata | input | 8 | Write data for index and data ports |
| tick_in | input | 1 | Prescaled tick, one cycle per tick |
| rdata | output | 8 | Combinational read value of the selected register |
| irq | output | 1 | Periodic interrupt pulse |
| bad_wr | output | 1 | One-cycle pulse after an unsupported write |

## Verification
The assertions assume that `idx_wr` and `dat_wr` are never high in the same cycle. They also assume that a write to register B never lands in the same cycle as a tick pulse, and that `tick_in` is a single-cycle pulse. The bench drives every strobe for exactly one cycle from the falling edge, one operation at a time. The timer is exercised only between register accesses, so these assumptions always hold. The divider is reduced to four ticks so that whole interrupt periods, and every legal and illegal control value, can be swept.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] IX_SEC  = 8'h00;
  localparam logic [7:0] IX_MIN  = 8'h02;
  localparam logic [7:0] IX_HOUR = 8'h04;
  localparam logic [7:0] IX_DOW  = 8'h06;
  localparam logic [7:0] IX_DOM  = 8'h07;
  localparam logic [7:0] IX_MON  = 8'h08;
  localparam logic [7:0] IX_YEAR = 8'h09;
  localparam logic [7:0] IX_CTLA = 8'h0A;
  localparam logic [7:0] IX_CTLB = 8'h0B;
  localparam logic [7:0] IX_CTLC = 8'h0C;
  localparam logic [7:0] IX_CTLD = 8'h0D;

  localparam int unsigned NUM_SLOTS = 7;
  localparam int unsigned SLOT_W    = 3;
  localparam logic [SLOT_W-1:0] SLOT_NONE = 3'd7;
  localparam logic [SLOT_W-1:0] SLOT_DOW  = 3'd3;

  localparam logic [6:0] CTLA_BASE   = 7'h26;
  localparam logic [7:0] CTLA_LEGAL  = 8'h26;
  localparam logic [7:0] CTLB_IMAGE  = 8'h46;
  localparam logic [7:0] CTLB_KEEP   = 8'hB7;
  localparam logic [7:0] CTLB_NEED   = 8'h06;
  localparam int unsigned CTLB_RUN_BIT = 6;

  // Map a register index onto a slot of the time bank.
  function automatic logic [SLOT_W-1:0] time_slot(input logic [7:0] ix);
    case (ix)
      IX_SEC:  time_slot = 3'd0;
      IX_MIN:  time_slot = 3'd1;
      IX_HOUR: time_slot = 3'd2;
      IX_DOW:  time_slot = 3'd3;
      IX_DOM:  time_slot = 3'd4;
      IX_MON:  time_slot = 3'd5;
      IX_YEAR: time_slot = 3'd6;
      default: time_slot = SLOT_NONE;
    endcase
  endfunction

  function automatic logic is_time_index(input logic [7:0] ix);
    return time_slot(ix) != SLOT_NONE;
  endfunction

  function automatic logic [7:0] ctla_image(input logic flag);
    return {flag, CTLA_BASE};
  endfunction

  function automatic logic ctlb_ok(input logic [7:0] v);
    return (v & CTLB_KEEP) == CTLB_NEED;
  endfunction

  function automatic logic [7:0] dow_image(input logic [7:0] stored);
    return stored + 8'd1;
  endfunction
endpackage

// File: rtl/rtc_time_bank.sv
module rtc_time_bank
  import rtc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [W-1:0]      wdata,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [W-1:0]      rd_val
);
  logic [W-1:0] field_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)
        field_q[s] <= '0;
      else if (wr_en && wr_slot == SLOT_W'(s))
        field_q[s] <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rd_slot == SLOT_W'(s))
        rd_val = (rd_slot == SLOT_DOW) ? dow_image(field_q[s]) : field_q[s];
    end
  end
endmodule

// File: rtl/rtc_ctrl_unit.sv
module rtc_ctrl_unit
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic       uip,
  output logic       bad_wr,
  output logic       start_req,
  output logic       stop_req
);
  logic legal_wr;
  logic b_write_ok;

  assign b_write_ok = wr_en && idx == IX_CTLB && ctlb_ok(wdata);
  assign start_req  = b_write_ok &&  wdata[CTLB_RUN_BIT];
  assign stop_req   = b_write_ok && !wdata[CTLB_RUN_BIT];

  always_comb begin
    if (is_time_index(idx))
      legal_wr = 1'b1;
    else if (idx == IX_CTLA)
      legal_wr = (wdata == CTLA_LEGAL);
    else if (idx == IX_CTLB)
      legal_wr = ctlb_ok(wdata);
    else
      legal_wr = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uip    <= 1'b0;
      bad_wr <= 1'b0;
    end else begin
      bad_wr <= wr_en && !legal_wr;
      if (rd_en && idx == IX_CTLA)
        uip <= !uip;
    end
  end
endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen #(
  parameter int unsigned TICKS_PER_IRQ = 32,
  parameter bit          RUN_AT_RESET  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic tick,
  output logic run,
  output logic irq
);
  localparam int unsigned CW = (TICKS_PER_IRQ < 2) ? 1 : $clog2(TICKS_PER_IRQ);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_IRQ - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= RUN_AT_RESET;
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (stop) begin
        run   <= 1'b0;
        cnt_q <= '0;
      end else if (start && !run) begin
        run   <= 1'b1;
        cnt_q <= '0;
      end else if (run && tick) begin
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          irq   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_periodic_regs.sv
module rtc_periodic_regs
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_IRQ = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic       dat_rd,
  input  logic [7:0] wdata,
  input  logic       tick_in,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       bad_wr
);
  logic [7:0]        cur_idx;
  logic [SLOT_W-1:0] cur_slot;
  logic [7:0]        bank_val;
  logic              uip_flag;
  logic              timer_run;
  logic              start_req;
  logic              stop_req;
  logic              time_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cur_idx <= '0;
    else if (idx_wr)
      cur_idx <= wdata;
  end

  assign cur_slot = time_slot(cur_idx);
  assign time_wr  = dat_wr && cur_slot != SLOT_NONE;

  rtc_time_bank #(.W(8)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (time_wr),
    .wr_slot (cur_slot),
    .wdata   (wdata),
    .rd_slot (cur_slot),
    .rd_val  (bank_val)
  );

  rtc_ctrl_unit u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (dat_wr),
    .rd_en     (dat_rd),
    .idx       (cur_idx),
    .wdata     (wdata),
    .uip       (uip_flag),
    .bad_wr    (bad_wr),
    .start_req (start_req),
    .stop_req  (stop_req)
  );

  rtc_periodic_gen #(.TICKS_PER_IRQ(TICKS_PER_IRQ), .RUN_AT_RESET(1'b1)) u_pgen (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_req),
    .stop  (stop_req),
    .tick  (tick_in),
    .run   (timer_run),
    .irq   (irq)
  );

  always_comb begin
    if (cur_slot != SLOT_NONE)
      rdata = bank_val;
    else if (cur_idx == IX_CTLA)
      rdata = ctla_image(uip_flag);
    else if (cur_idx == IX_CTLB)
      rdata = CTLB_IMAGE;
    else
      rdata = 8'h00;
  end
endmodule

// File: rtl/rtc_periodic_regs_chk.sv
module rtc_periodic_regs_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       dat_wr,
  input logic       dat_rd,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] idx,
  input logic       uip,
  input logic       run,
  input logic       irq,
  input logic       bad_wr
);
  p_uip_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && idx == IX_CTLA) |=> (uip != $past(uip)));

  p_uip_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_rd && idx == IX_CTLA) |=> $stable(uip));

  p_ctlb_image_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IX_CTLB) |-> (rdata == 8'h46));

  p_err_cd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && (idx == IX_CTLC || idx == IX_CTLD)) |=> bad_wr);

  p_no_err_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && is_time_index(idx)) |=> !bad_wr);

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx == IX_CTLB && (wdata & 8'hB7) == 8'h06 && wdata[6]) |=> run);

  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && idx == IX_CTLB && (wdata & 8'hB7) == 8'h06 && !wdata[6]) |=> !run);

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_needs_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(run));
endmodule

bind rtc_periodic_regs rtc_periodic_regs_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .dat_wr (dat_wr),
  .dat_rd (dat_rd),
  .wdata  (wdata),
  .rdata  (rdata),
  .idx    (cur_idx),
  .uip    (uip_flag),
  .run    (timer_run),
  .irq    (irq),
  .bad_wr (bad_wr)
);

// File: tb/rtc_periodic_regs_bench.sv
module rtc_periodic_regs_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idx_wr = 1'b0;
  logic       dat_wr = 1'b0;
  logic       dat_rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       tick_in = 1'b0;
  logic [7:0] rdata;
  logic       irq;
  logic       bad_wr;

  int checks = 0;
  int failures = 0;
  logic exp_uip = 1'b0;

  always #10 clk = ~clk;

  rtc_periodic_regs #(.TICKS_PER_IRQ(DIV)) u_rtc_periodic_regs (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .wdata(wdata), .tick_in(tick_in), .rdata(rdata), .irq(irq), .bad_wr(bad_wr)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] ix);
    @(negedge clk); idx_wr = 1'b1; wdata = ix;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  // Write to the selected register; bad_wr is then visible.
  task automatic put(input logic [7:0] v);
    @(negedge clk); dat_wr = 1'b1; wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic get(input logic [7:0] ix, output logic [7:0] v);
    set_idx(ix);
    @(negedge clk); dat_rd = 1'b1; #1 v = rdata;
    if (ix == 8'h0A) exp_uip = ~exp_uip;
    @(negedge clk); dat_rd = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_in = 1'b1;
    @(negedge clk); tick_in = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] ixs [6];
    ixs[0] = 8'h00; ixs[1] = 8'h02; ixs[2] = 8'h04;
    ixs[3] = 8'h07; ixs[4] = 8'h08; ixs[5] = 8'h09;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 idx0 rdata", rdata, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 bad_wr", {7'd0, bad_wr}, 8'h00);
    for (int i = 0; i < 6; i++) begin
      get(ixs[i], v); chk("R1 time field reset", v, 8'h00);
    end

    // R2: write distinct patterns then read all back
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 6; i++) begin
        set_idx(ixs[i]); put(8'(p * 53 + i * 17 + 1));
        chk("R7 time write legal", {7'd0, bad_wr}, 8'h00);
      end
      for (int i = 0; i < 6; i++) begin
        get(ixs[i], v); chk("R2 readback", v, 8'(p * 53 + i * 17 + 1));
      end
    end

    // R3: day of week sweep
    set_idx(8'h06);
    for (int d = 0; d < 256; d++) begin
      put(8'(d));
      #1 chk("R3 dow", rdata, 8'(d + 1));
    end

    // R4: toggling flag on reads of A
    for (int k = 0; k < 6; k++) begin
      logic e;
      e = exp_uip;
      get(8'h0A, v); chk("R4 ctla image", v, {e, 7'h26});
    end

    // R7 with R4: sweep writes to A; image and flag unchanged
    set_idx(8'h0A);
    for (int a = 0; a < 256; a++) begin
      put(8'(a));
      chk("R7 ctla write err", {7'd0, bad_wr}, (a == 8'h26) ? 8'h00 : 8'h01);
      #1 chk("R4 ctla after write", rdata, {exp_uip, 7'h26});
    end

    // R7 with R5: sweep writes to B
    set_idx(8'h0B);
    for (int b = 0; b < 256; b++) begin
      put(8'(b));
      chk("R7 ctlb write err", {7'd0, bad_wr}, ((b & 8'hB7) == 8'h06) ? 8'h00 : 8'h01);
      #1 chk("R5 ctlb image", rdata, 8'h46);
    end

    // R6/R7: unsupported slots
    begin
      logic [7:0] bad_ix [8];
      bad_ix[0] = 8'h01; bad_ix[1] = 8'h03; bad_ix[2] = 8'h05; bad_ix[3] = 8'h0C;
      bad_ix[4] = 8'h0D; bad_ix[5] = 8'h0E; bad_ix[6] = 8'h80; bad_ix[7] = 8'hFF;
      for (int i = 0; i < 8; i++) begin
        set_idx(bad_ix[i]); put(8'h5A);
        chk("R7 unsupported write err", {7'd0, bad_wr}, 8'h01);
        get(bad_ix[i], v); chk("R6 unsupported read", v, 8'h00);
      end
    end

    // R8/R9: restart timer from a known state
    set_idx(8'h0B);
    put(8'h06);
    put(8'h46);
    for (int n = 0; n < 4 * DIV; n++) begin
      pulse_tick();
      chk("R9 periodic irq", {7'd0, irq}, ((n % DIV) == DIV - 1) ? 8'h01 : 8'h00);
    end

    // R10: stopped timer stays silent
    put(8'h0E);
    for (int n = 0; n < 2 * DIV; n++) begin
      pulse_tick();
      chk("R10 no irq when stopped", {7'd0, irq}, 8'h00);
    end

    // R8: illegal write with bit 6 leaves timer stopped
    put(8'hC6);
    for (int n = 0; n < DIV; n++) begin
      pulse_tick();
      chk("R8 illegal start ignored", {7'd0, irq}, 8'h00);
    end

    // R8: start, then a second start mid-period keeps phase
    put(8'h46);
    for (int n = 0; n < DIV - 1; n++) begin
      pulse_tick();
      chk("R8 started count", {7'd0, irq}, 8'h00);
    end
    put(8'h4E);
    chk("R8 restart legal", {7'd0, bad_wr}, 8'h00);
    pulse_tick();
    chk("R8 phase kept", {7'd0, irq}, 8'h01);

    // R1: index port reloads and data ports follow it
    set_idx(8'h09); put(8'hA5);
    set_idx(8'h08); put(8'h3C);
    set_idx(8'h09); #1 chk("R1 index reselect", rdata, 8'hA5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule